// File: doc/BRIEF.md
# T1 Line Loopback Code Generator and Detector

This block sits on the serial payload path of a T1 interface. It inserts and recognises the in-band codes that ask a far end to open or close a line loopback. On the transmit side, a small control word picks one of three actions: pass the outgoing bit stream through unchanged, replace it with the repeating activate code, or replace it with the repeating deactivate code. A code can be sent framed, so the 193rd-bit framing positions keep their original content, or unframed, so the pattern also overwrites those positions.

On the receive side, two detectors watch the incoming stream, one tuned to each code. Each detector compares every accepted bit with the bit one pattern period earlier. It counts the disagreements and the ones over a fixed window of accepted bits. At the end of each window it sets or clears a status flag. In framed receive mode the bits marked as framing positions are left out of the check. The host reads the two flags and decides for itself whether a code has lasted long enough before it acts.

The generator is a three-state machine: GEN_PASS, GEN_ACT and GEN_DEACT. It moves at each clock edge to the state the control word requests, and the pattern phase restarts whenever the state changes. Each detector is a two-state machine. DET_FILL loads one pattern period of history after reset and then takes the transition to DET_RUN. DET_RUN evaluates one window after another and never leaves that state until reset.

Top module: `t1_lb_codec`

## Requirements
- R1: Control bits ctrl_i[1:0] pick the transmit action: 01 selects the activate code, 10 selects the deactivate code, and 00 or 11 select pass-through. The selection takes effect from the bit after the next rising clock edge. In pass-through, tx_data_o equals tx_data_i in the same cycle.
- R2: While the activate code is selected, the generated bits repeat 0,0,0,0,1. The first generated bit after the selection takes effect is the first 0 of that sequence.
- R3: While the deactivate code is selected, the generated bits repeat 0,0,1. The first generated bit after the selection takes effect is the first 0 of that sequence.
- R4: With ctrl_i[2]=0 (framed send), a bit with tx_fbit_i high passes tx_data_i through, and the pattern phase does not advance on that bit.
- R5: With ctrl_i[2]=1 (unframed send), the pattern also occupies the bits with tx_fbit_i high, and the phase advances on every bit.
- R6: status_o bit 3 is set at the end of a 1000-bit window in which at most 6 accepted bits differ from the bit 5 accepted bits earlier and the window holds between 180 and 220 ones. status_o bit 4 follows the same rule with a lag of 3 bits and a range of 313 to 353 ones. All other status_o bits are 0.
- R7: With ctrl_i[3]=1 (framed receive), bits with rx_fbit_i high are neither compared nor counted nor stored. With ctrl_i[3]=0, every bit is checked.
- R8: A code with 3 flipped bits inside a window is still detected. With 4 flipped bits it is not.
- R9: A flag changes only at the end of a window. A set flag clears at the end of the first window that fails its rule.
- R10: Streams that are not a code, such as a pseudo-random stream, all zeros or all ones, leave both flags at 0.
- R11: After reset the generator is in pass-through and both flags are 0. Each detector stores one pattern period of bits before its first window starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one T1 bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 4 | Control word: [1:0] code select, [2] unframed send, [3] framed receive |
| tx_data_i | input | 1 | Outgoing bit from the payload source |
| tx_fbit_i | input | 1 | High on the framing bit position of the outgoing stream |
| tx_data_o | output | 1 | Outgoing bit after code insertion |
| rx_data_i | input | 1 | Incoming line bit |
| rx_fbit_i | input | 1 | High on the framing bit position of the incoming stream |
| status_o | output | 8 | Status word: bit 3 activate seen, bit 4 deactivate seen |

## Verification
A generator phase that skips or repeats a step shows at tx_data_o on the very next code bit, because the single one in the pattern moves. This holds across framing positions too, since the bench models the phase hold from the requirements. A detector whose history, mismatch count or ones count goes wrong shows only at a window end. The bench therefore reads status_o after the first window closes and again in the middle of and after a later window. This catches a flag that moves early, that fails to set at the 3-error edge, or that never clears.

// File: rtl/t1lb_pkg.sv
package t1lb_pkg;

    typedef enum logic [1:0] {
        GEN_PASS  = 2'd0,
        GEN_ACT   = 2'd1,
        GEN_DEACT = 2'd2
    } gen_state_e;

    typedef enum logic {
        DET_FILL = 1'b0,
        DET_RUN  = 1'b1
    } det_state_e;

    typedef struct packed {
        logic       rx_framed;
        logic       tx_unframed;
        logic [1:0] code_sel;
    } lb_ctrl_t;

    function automatic gen_state_e sel_to_state(input logic [1:0] sel);
        gen_state_e s;
        unique case (sel)
            2'b01:   s = GEN_ACT;
            2'b10:   s = GEN_DEACT;
            default: s = GEN_PASS;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lb_ctrl_dec.sv
module lb_ctrl_dec
    import t1lb_pkg::*;
(
    input  logic [3:0]  ctrl_i,
    output gen_state_e  gen_req_o,
    output logic        tx_unframed_o,
    output logic        rx_framed_o
);

    lb_ctrl_t word;

    always_comb begin
        word          = lb_ctrl_t'(ctrl_i);
        gen_req_o     = sel_to_state(word.code_sel);
        tx_unframed_o = word.tx_unframed;
        rx_framed_o   = word.rx_framed;
    end

endmodule

// File: rtl/lb_code_gen.sv
module lb_code_gen
    import t1lb_pkg::*;
#(
    parameter int ACT_LEN   = 5,
    parameter int DEACT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  gen_state_e req_i,
    input  logic       unframed_i,
    input  logic       tx_data_i,
    input  logic       tx_fbit_i,
    output logic       tx_data_o
);

    localparam int MAX_LEN = (ACT_LEN > DEACT_LEN) ? ACT_LEN : DEACT_LEN;
    localparam int PW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam logic [PW-1:0] ACT_LAST   = PW'(ACT_LEN - 1);
    localparam logic [PW-1:0] DEACT_LAST = PW'(DEACT_LEN - 1);

    gen_state_e    state_q, state_n;
    logic [PW-1:0] phase_q;
    logic [PW-1:0] last_idx;
    logic          hold;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_PASS;
        else        state_q <= state_n;
    end

    // transitions: every state moves to the requested state
    always_comb begin
        state_n = state_q;
        unique case (req_i)
            GEN_ACT:   state_n = GEN_ACT;
            GEN_DEACT: state_n = GEN_DEACT;
            default:   state_n = GEN_PASS;
        endcase
    end

    assign last_idx = (state_q == GEN_ACT) ? ACT_LAST : DEACT_LAST;
    assign hold     = !unframed_i && tx_fbit_i;

    // pattern phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (state_n != state_q) begin
            phase_q <= '0;
        end else if (state_q != GEN_PASS && !hold) begin
            phase_q <= (phase_q == last_idx) ? '0 : phase_q + PW'(1);
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            GEN_ACT, GEN_DEACT: tx_data_o = hold ? tx_data_i : (phase_q == last_idx);
            default:            tx_data_o = tx_data_i;
        endcase
    end

    // R2
    act_phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_ACT) |-> (phase_q <= ACT_LAST));

    // R3
    deact_phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_DEACT) |-> (phase_q <= DEACT_LAST));

    // R4
    framed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GEN_PASS && !unframed_i && tx_fbit_i && state_n == state_q)
        |=> $stable(phase_q));

    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_n != state_q) |=> (phase_q == '0));

endmodule

// File: rtl/lb_code_det.sv
module lb_code_det
    import t1lb_pkg::*;
#(
    parameter int PERIOD  = 5,
    parameter int WIN_LEN = 1000,
    parameter int ERR_TOL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic framed_i,
    input  logic rx_data_i,
    input  logic rx_fbit_i,
    output logic hit_o
);

    localparam int CW       = $clog2(WIN_LEN + 1);
    localparam int FW       = $clog2(PERIOD + 1);
    localparam int MIS_MAX  = 2 * ERR_TOL;
    localparam int ONES_NOM = WIN_LEN / PERIOD;
    localparam int SLACK    = WIN_LEN / 50;
    localparam int ONES_LO  = ONES_NOM - SLACK;
    localparam int ONES_HI  = ONES_NOM + SLACK;

    det_state_e        state_q, state_n;
    logic [PERIOD-1:0] hist_q;
    logic [FW-1:0]     fill_cnt;
    logic [CW-1:0]     bit_cnt, mis_cnt, ones_cnt;
    logic [CW-1:0]     mis_nxt, ones_nxt;
    logic              hit_q;
    logic              take, mis_bit, win_end, win_ok;

    assign take     = !(framed_i && rx_fbit_i);
    assign mis_bit  = rx_data_i ^ hist_q[PERIOD-1];
    assign mis_nxt  = mis_cnt + CW'(mis_bit);
    assign ones_nxt = ones_cnt + CW'(rx_data_i);
    assign win_end  = take && (state_q == DET_RUN) && (bit_cnt == CW'(WIN_LEN - 1));
    assign win_ok   = (mis_nxt <= CW'(MIS_MAX)) &&
                      (ones_nxt >= CW'(ONES_LO)) && (ones_nxt <= CW'(ONES_HI));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DET_FILL;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            DET_FILL: if (take && fill_cnt == FW'(PERIOD - 1)) state_n = DET_RUN;
            DET_RUN:  state_n = DET_RUN;
        endcase
    end

    // datapath and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q   <= '0;
            fill_cnt <= '0;
            bit_cnt  <= '0;
            mis_cnt  <= '0;
            ones_cnt <= '0;
            hit_q    <= 1'b0;
        end else if (take) begin
            hist_q <= {hist_q[PERIOD-2:0], rx_data_i};
            unique case (state_q)
                DET_FILL: fill_cnt <= fill_cnt + FW'(1);
                DET_RUN: begin
                    if (win_end) begin
                        hit_q    <= win_ok;
                        bit_cnt  <= '0;
                        mis_cnt  <= '0;
                        ones_cnt <= '0;
                    end else begin
                        bit_cnt  <= bit_cnt + CW'(1);
                        mis_cnt  <= mis_nxt;
                        ones_cnt <= ones_nxt;
                    end
                end
            endcase
        end
    end

    assign hit_o = hit_q;

    // R9
    flag_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(hit_q));

    // R7
    skip_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (framed_i && rx_fbit_i) |=> ($stable(bit_cnt) && $stable(hist_q)));

    // R11
    fill_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_FILL) |-> !hit_q);

    // R6
    mis_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_cnt <= bit_cnt) && (ones_cnt <= bit_cnt));

endmodule

// File: rtl/t1_lb_codec.sv
module t1_lb_codec
    import t1lb_pkg::*;
#(
    parameter int ACT_LEN   = 5,
    parameter int DEACT_LEN = 3,
    parameter int WIN_LEN   = 1000,
    parameter int ERR_TOL   = 3,
    parameter int STAT_W    = 8,
    parameter int ACT_BIT   = 3,
    parameter int DEACT_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ctrl_i,
    input  logic              tx_data_i,
    input  logic              tx_fbit_i,
    output logic              tx_data_o,
    input  logic              rx_data_i,
    input  logic              rx_fbit_i,
    output logic [STAT_W-1:0] status_o
);

    localparam int NUM_DET = 2;

    gen_state_e         gen_req;
    logic               tx_unframed, rx_framed;
    logic [NUM_DET-1:0] hit;

    lb_ctrl_dec u_dec (
        .ctrl_i        (ctrl_i),
        .gen_req_o     (gen_req),
        .tx_unframed_o (tx_unframed),
        .rx_framed_o   (rx_framed)
    );

    lb_code_gen #(
        .ACT_LEN   (ACT_LEN),
        .DEACT_LEN (DEACT_LEN)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (gen_req),
        .unframed_i (tx_unframed),
        .tx_data_i  (tx_data_i),
        .tx_fbit_i  (tx_fbit_i),
        .tx_data_o  (tx_data_o)
    );

    for (genvar g = 0; g < NUM_DET; g++) begin : g_det
        lb_code_det #(
            .PERIOD  ((g == 0) ? ACT_LEN : DEACT_LEN),
            .WIN_LEN (WIN_LEN),
            .ERR_TOL (ERR_TOL)
        ) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .framed_i  (rx_framed),
            .rx_data_i (rx_data_i),
            .rx_fbit_i (rx_fbit_i),
            .hit_o     (hit[g])
        );
    end

    always_comb begin
        status_o            = '0;
        status_o[ACT_BIT]   = hit[0];
        status_o[DEACT_BIT] = hit[1];
    end

    // R10
    one_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: tb/test_t1_lb_codec.sv
module test_t1_lb_codec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ctrl_i = 4'h0;
    logic       tx_data_i = 1'b0, tx_fbit_i = 1'b0;
    logic       rx_data_i = 1'b0, rx_fbit_i = 1'b0;
    logic       tx_data_o;
    logic [7:0] status_o;

    int n_tests = 0, n_fail = 0;
    int idx = 0, ph = 0, mdl_st = 0, gmis = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    always #10 clk = ~clk;

    t1_lb_codec i_t1_lb_codec (
        .clk (clk), .rst_n (rst_n), .ctrl_i (ctrl_i),
        .tx_data_i (tx_data_i), .tx_fbit_i (tx_fbit_i), .tx_data_o (tx_data_o),
        .rx_data_i (rx_data_i), .rx_fbit_i (rx_fbit_i), .status_o (status_o)
    );

    // {sel[1:0], unframed tx, framed rx, errors[2:0], payload[1:0], exp act, exp deact}
    localparam int NV = 13;
    localparam logic [10:0] VEC [NV] = '{
        {2'b01, 1'b0, 1'b1, 3'd0, 2'd0, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b0, 3'd0, 2'd0, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b1},
        {2'b10, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1},
        {2'b01, 1'b0, 1'b1, 3'd3, 2'd0, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b0, 3'd4, 2'd0, 1'b0, 1'b0},
        {2'b10, 1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 1'b1},
        {2'b10, 1'b0, 1'b1, 3'd4, 2'd0, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b0, 3'd0, 2'd2, 1'b0, 1'b0},
        {2'b01, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0}
    };

    function automatic int dec_sel(input logic [1:0] s);
        return (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 0;
    endfunction

    function automatic bit err_at(input int i, input int n);
        return (n >= 1 && i == 200) || (n >= 2 && i == 450) ||
               (n >= 3 && i == 700) || (n >= 4 && i == 900);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] c);
        rst_n = 1'b0;
        ctrl_i = c;
        idx = 0; ph = 0; mdl_st = 0;
        tx_data_i = 1'b0; tx_fbit_i = 1'b0; rx_data_i = 1'b0; rx_fbit_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive_bits(input int n, input logic [1:0] pay, input int nerr);
        for (int k = 0; k < n; k++) begin
            logic fb, din, ex;
            int len;
            fb  = ((idx + 7) % 193 == 0);
            din = (idx == 0) ? 1'b1 : (pay == 2'd1) ? 1'b0 : (pay == 2'd2) ? 1'b1 : lfsr[0];
            tx_data_i = din;
            tx_fbit_i = fb;
            #1;
            len = (mdl_st == 1) ? 5 : 3;
            if (mdl_st == 0 || (!ctrl_i[2] && fb)) ex = din;
            else ex = (ph == len - 1);
            if (tx_data_o !== ex) gmis++;
            rx_data_i = tx_data_o ^ err_at(idx, nerr);
            rx_fbit_i = fb;
            @(posedge clk);
            if (mdl_st != 0 && !(!ctrl_i[2] && fb)) ph = (ph == len - 1) ? 0 : ph + 1;
            if (dec_sel(ctrl_i[1:0]) != mdl_st) ph = 0;
            mdl_st = dec_sel(ctrl_i[1:0]);
            idx++;
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state, pass-through before the first edge
        do_reset(4'b0001);
        check(status_o == 8'h00, "R11 status after reset", status_o, 0);
        tx_data_i = 1'b0; #1;
        check(tx_data_o == 1'b0, "R11 pass-through after reset", tx_data_o, 0);
        tx_data_i = 1'b1; #1;
        check(tx_data_o == 1'b1, "R11 pass-through after reset", tx_data_o, 1);
        @(negedge clk);
        rst_n = 1'b0;

        // vector table: R1 R2 R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            logic [10:0] e;
            string gtag;
            e = VEC[v];
            do_reset({e[7], e[8], e[10:9]});
            gmis = 0;
            drive_bits(1500, e[3:2], int'(e[6:4]));
            gtag = (dec_sel(e[10:9]) == 1) ? "R2,R4,R5 gen" :
                   (dec_sel(e[10:9]) == 2) ? "R3,R4,R5 gen" : "R1 gen";
            check(gmis == 0, gtag, gmis, 0);
            check(status_o[3] == e[1], "R6,R7,R8,R10 activate flag", status_o[3], e[1]);
            check(status_o[4] == e[0], "R6,R7,R8,R10 deactivate flag", status_o[4], e[0]);
            check((status_o & 8'hE7) == 0, "R6 reserved status bits", status_o, 0);
        end

        // R9: flag stays mid-window, clears at the first failing window end
        do_reset(4'b0101);
        gmis = 0;
        drive_bits(1100, 2'd0, 0);
        check(status_o[3] == 1'b1, "R9 flag set", status_o[3], 1);
        ctrl_i = 4'b0100;
        drive_bits(800, 2'd0, 0);
        check(status_o[3] == 1'b1, "R9 flag stable mid-window", status_o[3], 1);
        drive_bits(200, 2'd0, 0);
        check(status_o[3] == 1'b0, "R9 flag cleared", status_o[3], 0);
        check(gmis == 0, "R1 switch to pass", gmis, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule